// File: doc/BRIEF.md
# Pointer-Indexed Register Access Port

This block is the peripheral side of a register bank that exposes many internal registers through a single host location. In its idle state the location behaves as two registers: a read returns a live status byte, and a write loads a pointer. The access right after a pointer write is steered to the register the pointer named. That access may be a read or a write. Once it completes, the location falls back to status-and-pointer behaviour. Each pointer value therefore steers exactly one access.

The bank holds a command register, an interrupt mask, a byte-detect register, a threshold register and two single-byte mailboxes. The outbound mailbox runs from host to far side, and the inbound mailbox from far side to host. The two FIFO datapaths are not modelled. They appear only as six condition flags for the local port and six for the opposite port. A shift command chooses which of the two ports' flags the status byte shows. A reset flag in the status byte cannot be masked and clears when the status byte is read. An interrupt output combines the status byte with the mask. The output stays quiet after any reset until the far side arms it again.

Top module: `pidx_port`

## Requirements
- R1: After the synchronous reset the port is in idle mode, the interrupt output is low, and the mask, byte-detect, threshold and outbound mailbox registers all read back 0.
- R2: In idle mode, a host write loads the pointer and a host read returns the status byte. The single access after a pointer write goes to the selected register, and the port then returns to idle mode.
- R3: The pointer codes are: 1 for command, 2 for mask, 3 for byte-detect, 4 for outbound mailbox, 5 for threshold, and 6 for inbound mailbox. The mask holds 7 bits, and its bit 7 reads 0. Byte-detect, threshold and outbound mailbox are 8-bit read/write registers. The inbound mailbox is read-only, and writes to it change nothing.
- R4: A pointer value of 0, or of 7 and above, selects nothing. The access that follows it reads 0 and changes no register.
- R5: Status bit 7 is set by reset and by the chip-reset command. A status read returns it and clears it.
- R6: Command byte 0x40 makes the status byte show the opposite port's flags, and 0x00 restores the local port's flags. Any other value except 0x80 has no effect. The command register reads back 0x40 while the opposite port is shown and 0x00 otherwise.
- R7: Command byte 0x80 clears the mask, byte-detect, threshold, both mailboxes, their full flags, the shift state and the interrupt enable.
- R8: Status bits [6:3] carry flag inputs [5:2], and status bits [1:0] carry flag inputs [1:0]. Status bit 2 shows whether the inbound mailbox is full in the local view, or whether the outbound mailbox is full in the opposite view.
- R9: A host write to the outbound mailbox stores the byte and marks the mailbox full. A far-side take pulse clears both the value and the full flag, so the mailbox reads back 0. If a host write and a take fall in the same cycle, the host write wins.
- R10: A far-side put stores a byte in the inbound mailbox and marks it full. A host read of that mailbox returns the byte and clears the full flag. If a put and a host read fall in the same cycle, the read returns the old byte and the put wins, so the flag stays set and the new byte is kept.
- R11: The interrupt output is high exactly when the interrupt is enabled and either status bit 7 is set or some status bit in [6:0] is set with its mask bit set. A pulse on the arm input enables the interrupt, and reset or the chip-reset command disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access to the shared location this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid in the access cycle |
| own_flags | input | 6 | Local port FIFO condition flags |
| peer_flags | input | 6 | Opposite port FIFO condition flags |
| far_take | input | 1 | Far side consumed the outbound mailbox |
| far_put | input | 1 | Far side writes the inbound mailbox |
| far_data | input | 8 | Byte for the inbound mailbox |
| irq_arm | input | 1 | Far side enables the interrupt output |
| irq_out | output | 1 | Interrupt request to the host |

## Verification
Each mailbox is written from both sides, so two events can land on the same edge. A host write to the outbound mailbox can coincide with a far-side take. A host read of the inbound mailbox can coincide with a far-side put. The bench provokes both collisions by pulsing the far-side input inside the cycle of the host data access. It then judges the result through the host interface. The outbound mailbox must read back the new host byte. The inbound read must return the old byte while status bit 2 stays set, and the following read must return the new byte.

// File: rtl/pidx_pkg.sv
package pidx_pkg;
    localparam int DATA_W  = 8;
    localparam int FLAG_W  = 6;
    localparam int VIEW_W  = FLAG_W + 1;
    localparam int ST_RST  = 7;
    localparam int ST_MBOX = 2;

    localparam logic [DATA_W-1:0] CMD_CHIPRST = 8'h80;
    localparam logic [DATA_W-1:0] CMD_SHIFT   = 8'h40;
    localparam logic [DATA_W-1:0] CMD_UNSHIFT = 8'h00;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CMD  = 3'd1,
        SEL_MASK = 3'd2,
        SEL_BDET = 3'd3,
        SEL_OBOX = 3'd4,
        SEL_THR  = 3'd5,
        SEL_IBOX = 3'd6
    } sel_e;

    typedef struct packed {
        logic                stat_rd;
        logic                reg_rd;
        logic                reg_wr;
        sel_e                tgt;
        logic [DATA_W-1:0]   wdata;
    } acc_t;

    function automatic sel_e ptr_decode(input logic [DATA_W-1:0] v);
        case (v)
            8'd1:    return SEL_CMD;
            8'd2:    return SEL_MASK;
            8'd3:    return SEL_BDET;
            8'd4:    return SEL_OBOX;
            8'd5:    return SEL_THR;
            8'd6:    return SEL_IBOX;
            default: return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pidx_pointer.sv
module pidx_pointer
    import pidx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output acc_t              acc,
    output logic              data_mode
);
    logic in_data_q;
    sel_e tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_data_q <= 1'b0;
            tgt_q     <= SEL_NONE;
        end else if (sel) begin
            if (in_data_q) begin
                in_data_q <= 1'b0;
            end else if (wr) begin
                in_data_q <= 1'b1;
                tgt_q     <= ptr_decode(wdata);
            end
        end
    end

    always_comb begin
        acc.stat_rd = sel && !wr && !in_data_q;
        acc.reg_rd  = sel && !wr && in_data_q;
        acc.reg_wr  = sel && wr && in_data_q;
        acc.tgt     = tgt_q;
        acc.wdata   = wdata;
    end

    assign data_mode = in_data_q;
endmodule

// File: rtl/pidx_regs.sv
module pidx_regs
    import pidx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic              far_take,
    input  logic              far_put,
    input  logic [DATA_W-1:0] far_data,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [VIEW_W-1:0] mask,
    output logic              shift,
    output logic              chip_rst,
    output logic              obox_full,
    output logic              ibox_full,
    output logic [DATA_W-1:0] obox_val
);
    logic [VIEW_W-1:0] mask_q;
    logic [DATA_W-1:0] bdet_q, thr_q, obox_q, ibox_q;
    logic              shift_q, ofull_q, ifull_q;
    logic              wr_cmd, wr_obox, rd_ibox, clr;

    assign wr_cmd   = acc.reg_wr && (acc.tgt == SEL_CMD);
    assign wr_obox  = acc.reg_wr && (acc.tgt == SEL_OBOX);
    assign rd_ibox  = acc.reg_rd && (acc.tgt == SEL_IBOX);
    assign chip_rst = wr_cmd && (acc.wdata == CMD_CHIPRST);
    assign clr      = rst || chip_rst;

    always_ff @(posedge clk) begin
        if (clr) begin
            mask_q  <= '0;
            bdet_q  <= '0;
            thr_q   <= '0;
            shift_q <= 1'b0;
        end else if (acc.reg_wr) begin
            case (acc.tgt)
                SEL_MASK: mask_q <= acc.wdata[VIEW_W-1:0];
                SEL_BDET: bdet_q <= acc.wdata;
                SEL_THR:  thr_q  <= acc.wdata;
                SEL_CMD: begin
                    if (acc.wdata == CMD_SHIFT)        shift_q <= 1'b1;
                    else if (acc.wdata == CMD_UNSHIFT) shift_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            obox_q  <= '0;
            ofull_q <= 1'b0;
        end else if (wr_obox) begin
            obox_q  <= acc.wdata;
            ofull_q <= 1'b1;
        end else if (far_take) begin
            obox_q  <= '0;
            ofull_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            ibox_q  <= '0;
            ifull_q <= 1'b0;
        end else if (far_put) begin
            ibox_q  <= far_data;
            ifull_q <= 1'b1;
        end else if (rd_ibox) begin
            ifull_q <= 1'b0;
        end
    end

    always_comb begin
        case (acc.tgt)
            SEL_CMD:  reg_rdata = shift_q ? CMD_SHIFT : CMD_UNSHIFT;
            SEL_MASK: reg_rdata = {1'b0, mask_q};
            SEL_BDET: reg_rdata = bdet_q;
            SEL_OBOX: reg_rdata = obox_q;
            SEL_THR:  reg_rdata = thr_q;
            SEL_IBOX: reg_rdata = ibox_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign mask      = mask_q;
    assign shift     = shift_q;
    assign obox_full = ofull_q;
    assign ibox_full = ifull_q;
    assign obox_val  = obox_q;
endmodule

// File: rtl/pidx_status.sv
module pidx_status
    import pidx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_rst,
    input  logic              stat_rd,
    input  logic              shift,
    input  logic [FLAG_W-1:0] own_flags,
    input  logic [FLAG_W-1:0] peer_flags,
    input  logic              obox_full,
    input  logic              ibox_full,
    input  logic [VIEW_W-1:0] mask,
    input  logic              irq_arm,
    output logic [DATA_W-1:0] status,
    output logic              irq,
    output logic              rst_flag
);
    logic              rflag_q, irq_en_q;
    logic [VIEW_W-1:0] view;

    for (genvar i = 0; i < VIEW_W; i++) begin : g_view
        if (i == ST_MBOX) begin : g_mbox
            assign view[i] = shift ? obox_full : ibox_full;
        end else if (i < ST_MBOX) begin : g_lo
            assign view[i] = shift ? peer_flags[i] : own_flags[i];
        end else begin : g_hi
            assign view[i] = shift ? peer_flags[i-1] : own_flags[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || chip_rst)  rflag_q <= 1'b1;
        else if (stat_rd)     rflag_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || chip_rst)  irq_en_q <= 1'b0;
        else if (irq_arm)     irq_en_q <= 1'b1;
    end

    assign status   = {rflag_q, view};
    assign irq      = irq_en_q && (rflag_q || |(view & mask));
    assign rst_flag = rflag_q;
endmodule

// File: rtl/pidx_port.sv
module pidx_port
    import pidx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [5:0]        own_flags,
    input  logic [5:0]        peer_flags,
    input  logic              far_take,
    input  logic              far_put,
    input  logic [7:0]        far_data,
    input  logic              irq_arm,
    output logic              irq_out
);
    acc_t              acc;
    logic              ptr_dmode;
    logic [DATA_W-1:0] reg_rdata, status, obox_q;
    logic [VIEW_W-1:0] mask;
    logic              shift, chip_rst, obox_full, ibox_full, rst_flag;

    pidx_pointer u_ptr (
        .clk(clk), .rst(rst), .sel(host_sel), .wr(host_wr),
        .wdata(host_wdata), .acc(acc), .data_mode(ptr_dmode)
    );

    pidx_regs u_regs (
        .clk(clk), .rst(rst), .acc(acc),
        .far_take(far_take), .far_put(far_put), .far_data(far_data),
        .reg_rdata(reg_rdata), .mask(mask), .shift(shift),
        .chip_rst(chip_rst), .obox_full(obox_full),
        .ibox_full(ibox_full), .obox_val(obox_q)
    );

    pidx_status u_stat (
        .clk(clk), .rst(rst), .chip_rst(chip_rst), .stat_rd(acc.stat_rd),
        .shift(shift), .own_flags(own_flags), .peer_flags(peer_flags),
        .obox_full(obox_full), .ibox_full(ibox_full), .mask(mask),
        .irq_arm(irq_arm), .status(status), .irq(irq_out),
        .rst_flag(rst_flag)
    );

    always_comb begin
        if (acc.stat_rd)     host_rdata = status;
        else if (acc.reg_rd) host_rdata = reg_rdata;
        else                 host_rdata = '0;
    end
endmodule

// File: rtl/pidx_chk.sv
module pidx_chk
    import pidx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       host_sel,
    input logic       host_wr,
    input logic [7:0] host_rdata,
    input logic       far_take,
    input logic       far_put,
    input logic       irq_out,
    input logic       ptr_dmode,
    input sel_e       ptr_tgt,
    input logic       chip_rst,
    input logic [7:0] obox_q,
    input logic       ibox_full,
    input logic       rst_flag
);
    logic obox_host_wr;
    assign obox_host_wr = host_sel && host_wr && ptr_dmode && (ptr_tgt == SEL_OBOX);

    assert_enter_data_R2: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_wr && !ptr_dmode) |=> ptr_dmode);

    assert_revert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (host_sel && ptr_dmode) |=> !ptr_dmode);

    assert_mask_top_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (host_sel && !host_wr && ptr_dmode && ptr_tgt == SEL_MASK) |-> !host_rdata[7]);

    assert_invalid_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (host_sel && !host_wr && ptr_dmode && ptr_tgt == SEL_NONE) |-> (host_rdata == 8'h00));

    assert_flag_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (host_sel && !host_wr && !ptr_dmode) |=> !rst_flag);

    assert_take_empties_R9: assert property (@(posedge clk) disable iff (rst)
        (far_take && !obox_host_wr) |=> (obox_q == 8'h00));

    assert_put_fills_R10: assert property (@(posedge clk) disable iff (rst)
        (far_put && !chip_rst) |=> ibox_full);

    assert_cmdrst_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        chip_rst |=> !irq_out);
endmodule

bind pidx_port pidx_chk u_chk (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
    .host_rdata(host_rdata), .far_take(far_take), .far_put(far_put),
    .irq_out(irq_out), .ptr_dmode(ptr_dmode), .ptr_tgt(acc.tgt),
    .chip_rst(chip_rst), .obox_q(obox_q), .ibox_full(ibox_full),
    .rst_flag(rst_flag)
);

// File: tb/sim_pidx_port.sv
module sim_pidx_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_sel = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [5:0] own_flags = '0, peer_flags = '0;
    logic       far_take = 1'b0, far_put = 1'b0, irq_arm = 1'b0;
    logic [7:0] far_data = '0;
    logic       irq_out;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pidx_port u0 (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .own_flags(own_flags), .peer_flags(peer_flags),
        .far_take(far_take), .far_put(far_put), .far_data(far_data),
        .irq_arm(irq_arm), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [7:0] d, input logic take,
                       input logic put, input logic [7:0] pd, output logic [7:0] rd);
        @(negedge clk);
        host_sel = 1'b1; host_wr = wr; host_wdata = d;
        far_take = take; far_put = put; far_data = pd;
        #1 rd = host_rdata;
        @(posedge clk);
        #1;
        host_sel = 1'b0; host_wr = 1'b0; far_take = 1'b0; far_put = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] code, input logic [7:0] v);
        logic [7:0] dummy;
        acc(1'b1, code, 1'b0, 1'b0, 8'h00, dummy);
        acc(1'b1, v, 1'b0, 1'b0, 8'h00, dummy);
    endtask

    task automatic rreg(input logic [7:0] code, output logic [7:0] v);
        logic [7:0] dummy;
        acc(1'b1, code, 1'b0, 1'b0, 8'h00, dummy);
        acc(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, v);
    endtask

    task automatic rstat(output logic [7:0] v);
        acc(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, v);
    endtask

    task automatic pulse_far(input logic take, input logic put, input logic [7:0] pd, input logic arm);
        @(negedge clk);
        far_take = take; far_put = put; far_data = pd; irq_arm = arm;
        @(posedge clk);
        #1;
        far_take = 1'b0; far_put = 1'b0; irq_arm = 1'b0;
    endtask

    function automatic logic [7:0] view(input logic [5:0] f, input logic mb);
        return {1'b0, f[5:2], mb, f[1:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, v, exp;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        chk("R1 irq after reset", {7'b0, irq_out}, 8'h00);
        rreg(8'd2, r); chk("R1 mask reset", r, 8'h00);
        rreg(8'd3, r); chk("R1 bdet reset", r, 8'h00);
        rreg(8'd5, r); chk("R1 thr reset", r, 8'h00);
        rreg(8'd4, r); chk("R1 obox reset", r, 8'h00);
        // R5: reset flag seen once, then cleared
        rstat(r); chk("R5 reset flag set", r, 8'h80);
        rstat(r); chk("R5 reset flag cleared", r, 8'h00);

        // R3 / R2: sweep read/write registers, status after each data access
        for (int pass = 0; pass < 16; pass++) begin
            for (int c = 2; c <= 5; c++) begin
                if (c == 4) continue;
                v = 8'((pass * 37 + c * 91) ^ 8'hA5);
                wreg(8'(c), v);
                rstat(r); chk("R2 idle after write", r, 8'h00);
                rreg(8'(c), r);
                exp = (c == 2) ? {1'b0, v[6:0]} : v;
                chk("R3 readback", r, exp);
                rstat(r); chk("R2 idle after read", r, 8'h00);
            end
        end
        wreg(8'd2, 8'h00);
        wreg(8'd3, 8'h3C);
        wreg(8'd5, 8'hC3);

        // R4: every invalid pointer value, write then read
        for (int p = 0; p < 256; p++) begin
            if (p >= 1 && p <= 6) continue;
            wreg(8'(p), 8'hFF);
            rreg(8'(p), r);
            chk("R4 invalid read zero", r, 8'h00);
        end
        rreg(8'd2, r); chk("R4 mask untouched", r, 8'h00);
        rreg(8'd3, r); chk("R4 bdet untouched", r, 8'h3C);
        rreg(8'd5, r); chk("R4 thr untouched", r, 8'hC3);
        rreg(8'd4, r); chk("R4 obox untouched", r, 8'h00);
        rstat(r); chk("R4 no reset flag", r, 8'h00);

        // R8: local flag sweep
        for (int f = 0; f < 64; f++) begin
            own_flags = 6'(f); peer_flags = ~6'(f);
            rstat(r); chk("R8 local view", r, view(6'(f), 1'b0));
        end

        // R6: shift to opposite port
        wreg(8'd1, 8'h40);
        rreg(8'd1, r); chk("R6 cmd readback shifted", r, 8'h40);
        for (int f = 0; f < 64; f += 5) begin
            own_flags = 6'(f); peer_flags = 6'(f * 3 + 1);
            rstat(r); chk("R6 opposite view", r, view(6'(f * 3 + 1), 1'b0));
        end
        wreg(8'd1, 8'h13);
        rreg(8'd1, r); chk("R6 other command ignored", r, 8'h40);
        own_flags = 6'h00; peer_flags = 6'h00;

        // R9 / R8: outbound mailbox
        wreg(8'd4, 8'h5A);
        rreg(8'd4, r); chk("R9 obox readback", r, 8'h5A);
        rstat(r); chk("R8 opposite bit2 obox full", r, 8'h04);
        pulse_far(1'b1, 1'b0, 8'h00, 1'b0);
        rreg(8'd4, r); chk("R9 take clears", r, 8'h00);
        rstat(r); chk("R9 full cleared", r, 8'h00);
        acc(1'b1, 8'd4, 1'b0, 1'b0, 8'h00, r);
        acc(1'b1, 8'hA7, 1'b1, 1'b0, 8'h00, r);
        rreg(8'd4, r); chk("R9 collision host wins", r, 8'hA7);
        rstat(r); chk("R9 collision full", r, 8'h04);
        pulse_far(1'b1, 1'b0, 8'h00, 1'b0);

        wreg(8'd1, 8'h00);
        rreg(8'd1, r); chk("R6 unshift readback", r, 8'h00);

        // R10: inbound mailbox
        pulse_far(1'b0, 1'b1, 8'h3C, 1'b0);
        rstat(r); chk("R10 put sets bit2", r, 8'h04);
        wreg(8'd6, 8'h77);
        rstat(r); chk("R3 ibox write leaves full", r, 8'h04);
        acc(1'b1, 8'd6, 1'b0, 1'b0, 8'h00, r);
        acc(1'b0, 8'h00, 1'b0, 1'b1, 8'h99, r);
        chk("R10 collision old byte", r, 8'h3C);
        rstat(r); chk("R10 collision flag stays", r, 8'h04);
        rreg(8'd6, r); chk("R10 new byte", r, 8'h99);
        rstat(r); chk("R10 read clears flag", r, 8'h00);

        // R11: interrupt per status bit
        pulse_far(1'b0, 1'b0, 8'h00, 1'b1);
        for (int b = 0; b < 7; b++) begin
            if (b == 2) continue;
            wreg(8'd2, 8'(1 << b));
            own_flags = (b < 2) ? 6'(1 << b) : 6'(1 << (b - 1));
            #1 chk("R11 masked bit raises irq", {7'b0, irq_out}, 8'h01);
            own_flags = ~own_flags;
            #1 chk("R11 other bits no irq", {7'b0, irq_out}, 8'h00);
        end
        own_flags = 6'h3F;
        wreg(8'd2, 8'h00);
        chk("R11 mask zero no irq", {7'b0, irq_out}, 8'h00);
        wreg(8'd2, 8'h7F);
        wreg(8'd3, 8'h11);
        wreg(8'd5, 8'h22);
        wreg(8'd4, 8'h33);
        wreg(8'd1, 8'h40);

        // R7: chip reset command
        wreg(8'd1, 8'h80);
        chk("R7 irq disabled", {7'b0, irq_out}, 8'h00);
        rreg(8'd2, r); chk("R7 mask cleared", r, 8'h00);
        rreg(8'd3, r); chk("R7 bdet cleared", r, 8'h00);
        rreg(8'd5, r); chk("R7 thr cleared", r, 8'h00);
        rreg(8'd4, r); chk("R7 obox cleared", r, 8'h00);
        rreg(8'd1, r); chk("R7 shift cleared", r, 8'h00);
        pulse_far(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R11 reset flag unmaskable", {7'b0, irq_out}, 8'h01);
        rstat(r); chk("R5 flag after cmd reset", r, 8'h80 | view(6'h3F, 1'b0));
        chk("R11 irq drops after status read", {7'b0, irq_out}, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule